// File: doc/BRIEF.md
# SPI Flash Software-Sequenced Cycle Engine

This block runs one flash command on an SPI bus each time software writes the go bit. The write carries a control word that sets the bus rate, an opcode taken from an eight-entry menu, an optional 24-bit address and an optional data phase of one to four bytes. The block shifts the command out on MOSI in SPI mode 0, most significant bit first, and captures MISO at the same time. It shows the cycle-in-progress and cycle-done flags.

An atomic mode runs three steps under one go. First it sends a single-byte prefix command, picked from two prefix opcodes. Then it sends the primary command. Then it reads the flash status register again and again until the busy bit clears. No other cycle can start during the sequence, and the in-progress flag stays set through the whole of it. Register-bus decode is not part of this block. The address comes in as a plain input.

Top module: `spi_swseq_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, cycle_busy is 0 and cycle_done is 0.
- R2: A one-cycle pulse on go while idle sets cycle_busy and clears cycle_done at the next clock edge. The cfg_* values present with that pulse define the cycle.
- R3: A primary frame is built in this order. First the opcode op_menu[8*k+7:8*k], where k is cfg_op_sel. Then cfg_addr if cfg_addr_en is 1. Then the data bytes. Bits go out MSB first in SPI mode 0: MOSI is set up while SCK is low, MISO is sampled on the SCK rising edge, and SCK is low whenever chip select is high.
- R4: When cfg_data_en is 0, the frame has no data phase, cfg_byte_cnt has no effect, and rdata keeps its previous value.
- R5: When cfg_data_en is 1, the frame carries cfg_byte_cnt+1 data bytes. The bytes sent are cfg_wdata[8n-1:0], sent from bit 8n-1 downward, where n is the byte count. At the end of the cycle, rdata holds the 8n bits received in the data phase, right-aligned with the first bit received most significant, and its upper bits are zero.
- R6: For frequency code 3'b001, SCK stays high for HALF_33 system clocks per bit. Code 3'b000 and every reserved code use HALF_20. When cfg_read_cycle is 1, HALF_20 is used whatever the code.
- R7: In atomic mode (cfg_atomic=1) the engine sends three kinds of frame in order. First an 8-bit prefix frame holding pfx_ops[7:0] when cfg_pfx_sel is 0 and pfx_ops[15:8] when it is 1. Then the primary frame. Then 16-bit status polls: opcode 8'h05 followed by 8 clocks of input. A new poll is sent while bit 0 of the byte just read is 1.
- R8: In atomic mode, cycle_busy stays 1 and cycle_done stays 0 until a poll returns bit 0 equal to 0. In every mode, the end of a cycle clears cycle_busy and sets cycle_done. cycle_done then holds until the next accepted go.
- R9: A go pulse while cycle_busy is 1 is ignored: it adds no frame and does not change the cycle in progress.
- R10: Chip select stays low for the whole of each frame. It goes high for at least GAP_CYC system clocks between the frames of an atomic sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | One-cycle start pulse (go bit write) |
| cfg_freq | input | 3 | Bus rate code |
| cfg_data_en | input | 1 | Data phase present |
| cfg_byte_cnt | input | 2 | Data bytes minus one |
| cfg_op_sel | input | 3 | Opcode menu index |
| cfg_pfx_sel | input | 1 | Prefix opcode index |
| cfg_atomic | input | 1 | Run prefix, primary and busy polling |
| cfg_read_cycle | input | 1 | Plain read cycle, forces the slow rate |
| cfg_addr_en | input | 1 | Address phase present |
| cfg_addr | input | 24 | Flash address |
| cfg_wdata | input | 32 | Outgoing data bytes |
| op_menu | input | 64 | Eight programmed opcodes |
| pfx_ops | input | 16 | Two prefix opcodes |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| rdata | output | 32 | Captured data bytes |
| cycle_busy | output | 1 | Cycle in progress |
| cycle_done | output | 1 | Cycle completed |

## Verification
The bench builds the engine with HALF_20=4, HALF_33=2 and GAP_CYC=3. The two rates then differ in SCK high time, so a measured pulse width shows which divider was picked for the normal, reserved and read-forced codes. A three-clock gap can be seen at the monitor's sampling rate. The bench models the flash and can hold its busy bit for a chosen number of polls, so it drives sequences with zero and with several repeated polls. It also issues a go pulse in the middle of a long atomic sequence.

// File: rtl/spi_swseq_pkg.sv
package spi_swseq_pkg;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_PFX, S_PRI, S_POLL} seq_state_e;

  localparam logic [7:0] STATUS_RD_OP = 8'h05;
  localparam logic [2:0] FREQ_FAST    = 3'b001;

  // Number of SCK periods in a primary frame.
  function automatic logic [6:0] frame_len(input logic addr_en, input logic data_en,
                                           input logic [1:0] cnt);
    logic [6:0] n;
    n = 7'd8;
    if (addr_en) n = n + 7'd24;
    if (data_en) n = n + (7'(cnt) + 7'd1) * 7'd8;
    return n;
  endfunction

  // Left-aligned primary frame: opcode, optional address, optional data.
  function automatic logic [63:0] build_frame(input logic [7:0] op, input logic addr_en,
                                              input logic [23:0] addr, input logic data_en,
                                              input logic [1:0] cnt, input logic [31:0] wd);
    logic [63:0] v;
    logic [6:0]  p;
    logic [5:0]  nb8;
    logic [31:0] dl;
    v = {op, 56'd0};
    p = 7'd56;
    if (addr_en) begin
      v[55:32] = addr;
      p = 7'd32;
    end
    if (data_en) begin
      nb8 = (6'(cnt) + 6'd1) * 6'd8;
      dl  = wd << (6'd32 - nb8);
      v   = v | ({dl, 32'd0} >> (7'd64 - p));
    end
    return v;
  endfunction

  // Mask of the low 8*(cnt+1) bits.
  function automatic logic [31:0] rx_mask(input logic [1:0] cnt);
    logic [32:0] m;
    m = (33'd1 << ((6'(cnt) + 6'd1) * 6'd8)) - 33'd1;
    return m[31:0];
  endfunction

  // 1 selects the fast divider; reserved codes and read cycles stay slow.
  function automatic logic use_fast(input logic [2:0] f, input logic rd);
    return (f == FREQ_FAST) && !rd;
  endfunction

endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [63:0]   tx_vec,
  input  logic [6:0]    nbits,
  input  logic [CW-1:0] half,
  input  logic          miso,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  output logic [31:0]   rx_word,
  output logic          frame_done
);
  logic          active;
  logic [63:0]   tx_sr;
  logic [6:0]    left;
  logic [CW-1:0] half_q;
  logic          tick;

  spi_sck_div #(.CW(CW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active), .half(half_q), .tick(tick)
  );

  assign mosi = active & tx_sr[63];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; tx_sr <= '0; left <= '0; half_q <= '0;
      sck <= 1'b0; cs_n <= 1'b1; rx_word <= '0; frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1; cs_n <= 1'b0; sck <= 1'b0;
        tx_sr <= tx_vec; left <= nbits; half_q <= half;
      end else if (tick) begin
        if (!sck) begin
          sck     <= 1'b1;
          rx_word <= {rx_word[30:0], miso};
        end else begin
          sck   <= 1'b0;
          tx_sr <= {tx_sr[62:0], 1'b0};
          left  <= left - 7'd1;
          if (left == 7'd1) begin
            active <= 1'b0; cs_n <= 1'b1; frame_done <= 1'b1;
          end
        end
      end
    end
  end

  assert_sck_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_rate_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(half_q));
  assert_cs_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && left > 7'd1) |=> !cs_n);
endmodule

// File: rtl/spi_swseq_engine.sv
module spi_swseq_engine
  import spi_swseq_pkg::*;
#(
  parameter int HALF_20 = 3,
  parameter int HALF_33 = 2,
  parameter int GAP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [2:0]  cfg_freq,
  input  logic        cfg_data_en,
  input  logic [1:0]  cfg_byte_cnt,
  input  logic [2:0]  cfg_op_sel,
  input  logic        cfg_pfx_sel,
  input  logic        cfg_atomic,
  input  logic        cfg_read_cycle,
  input  logic        cfg_addr_en,
  input  logic [23:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [63:0] op_menu,
  input  logic [15:0] pfx_ops,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [31:0] rdata,
  output logic        cycle_busy,
  output logic        cycle_done
);
  localparam int HMAX = (HALF_20 > HALF_33) ? HALF_20 : HALF_33;
  localparam int CW   = $clog2(HMAX + 1) + 1;
  localparam int GW   = $clog2(GAP_CYC + 1) + 1;

  seq_state_e  state, nxt;
  logic [GW-1:0] gap_cnt;
  logic        start;
  logic [2:0]  l_freq, l_op;
  logic        l_read, l_data, l_pfx, l_atomic, l_addr_en;
  logic [1:0]  l_cnt;
  logic [23:0] l_addr;
  logic [31:0] l_wdata;
  logic [63:0] tx_vec;
  logic [6:0]  nbits;
  logic [CW-1:0] half;
  logic [31:0] rx_word;
  logic        frame_done;

  // Named events for the assertions.
  logic go_take, go_drop, poll_again, seq_end;
  assign go_take    = go && (state == S_IDLE);
  assign go_drop    = go && (state != S_IDLE);
  assign poll_again = (state == S_POLL) && frame_done && rx_word[0];
  assign seq_end    = frame_done && (((state == S_PRI) && !l_atomic) ||
                                     ((state == S_POLL) && !rx_word[0]));

  assign half = use_fast(l_freq, l_read) ? CW'(HALF_33) : CW'(HALF_20);

  always_comb begin
    case (state)
      S_PFX:   begin tx_vec = {pfx_ops[8*l_pfx +: 8], 56'd0}; nbits = 7'd8;  end
      S_POLL:  begin tx_vec = {STATUS_RD_OP, 56'd0};          nbits = 7'd16; end
      default: begin
        tx_vec = build_frame(op_menu[8*l_op +: 8], l_addr_en, l_addr, l_data, l_cnt, l_wdata);
        nbits  = frame_len(l_addr_en, l_data, l_cnt);
      end
    endcase
  end

  spi_frame_shifter #(.CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_vec(tx_vec), .nbits(nbits),
    .half(half), .miso(spi_miso), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .rx_word(rx_word), .frame_done(frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; nxt <= S_PRI; gap_cnt <= '0; start <= 1'b0;
      l_freq <= '0; l_op <= '0; l_read <= 1'b0; l_data <= 1'b0; l_pfx <= 1'b0;
      l_atomic <= 1'b0; l_addr_en <= 1'b0; l_cnt <= '0; l_addr <= '0; l_wdata <= '0;
      rdata <= '0; cycle_busy <= 1'b0; cycle_done <= 1'b0;
    end else begin
      start <= 1'b0;
      case (state)
        S_IDLE: if (go_take) begin
          l_freq <= cfg_freq; l_op <= cfg_op_sel; l_read <= cfg_read_cycle;
          l_data <= cfg_data_en; l_pfx <= cfg_pfx_sel; l_atomic <= cfg_atomic;
          l_addr_en <= cfg_addr_en; l_cnt <= cfg_byte_cnt; l_addr <= cfg_addr;
          l_wdata <= cfg_wdata;
          cycle_busy <= 1'b1; cycle_done <= 1'b0;
          state <= S_GAP; gap_cnt <= '0; nxt <= cfg_atomic ? S_PFX : S_PRI;
        end
        S_GAP: if (gap_cnt == '0) begin
          start <= 1'b1; state <= nxt;
        end else gap_cnt <= gap_cnt - GW'(1);
        S_PFX: if (frame_done) begin
          state <= S_GAP; gap_cnt <= GW'(GAP_CYC - 1); nxt <= S_PRI;
        end
        S_PRI: if (frame_done) begin
          if (l_data) rdata <= rx_word & rx_mask(l_cnt);
          if (l_atomic) begin
            state <= S_GAP; gap_cnt <= GW'(GAP_CYC - 1); nxt <= S_POLL;
          end else begin
            state <= S_IDLE; cycle_busy <= 1'b0; cycle_done <= 1'b1;
          end
        end
        S_POLL: if (frame_done) begin
          if (rx_word[0]) begin
            state <= S_GAP; gap_cnt <= GW'(GAP_CYC - 1); nxt <= S_POLL;
          end else begin
            state <= S_IDLE; cycle_busy <= 1'b0; cycle_done <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_take |=> (cycle_busy && !cycle_done));
  assert_go_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go_drop |=> ($stable(l_op) && $stable(l_atomic) && cycle_busy));
  assert_poll_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_again |=> (cycle_busy && !cycle_done));
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cycle_busy && cycle_done));
  assert_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> (cycle_done && !cycle_busy));
  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP) |-> spi_cs_n);
endmodule

// File: tb/spi_swseq_engine_tb.sv
module spi_swseq_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H20 = 4, H33 = 2, GAPC = 3;

  typedef struct { logic [63:0] bits; int n; int half; } frame_t;

  logic clk = 0, rst_n = 0, go = 0;
  logic [2:0] cfg_freq = 0, cfg_op_sel = 0;
  logic cfg_data_en = 0, cfg_pfx_sel = 0, cfg_atomic = 0, cfg_read_cycle = 0, cfg_addr_en = 0;
  logic [1:0] cfg_byte_cnt = 0;
  logic [23:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [63:0] op_menu = 64'h0B03_02D8_209F_0601;
  logic [15:0] pfx_ops = 16'h5006;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic [31:0] rdata;
  logic cycle_busy, cycle_done;

  int checks = 0, failures = 0;
  frame_t exp_q[$];
  logic [63:0] slave_pat = 64'hC3A5_5A3C_9612_E7F1;
  int polls_busy = 0;
  logic [63:0] obs = 0;
  int idx = 0, hi_cnt = 0, hi_first = 0;
  logic prev_cs = 1, prev_sck = 0;
  int gap_len = 0, min_gap = 1000;
  logic in_seq = 0;

  spi_swseq_engine #(.HALF_20(H20), .HALF_33(H33), .GAP_CYC(GAPC)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic ok, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Flash model: status byte 8'h01 while busy, else pattern bits.
  function automatic logic slave_bit(input int i, input logic [63:0] o, input int pb,
                                     input logic [63:0] pat);
    if (i >= 64) return 1'b0;
    if (i >= 8 && o[63:56] == 8'h05) return (i == 15) ? (pb > 0) : 1'b0;
    return pat[63-i];
  endfunction
  assign spi_miso = spi_cs_n ? 1'b0 : slave_bit(idx, obs, polls_busy, slave_pat);

  // Monitor: samples on the falling clock edge, compares each frame with the queue.
  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      idx = 0; obs = 0; hi_cnt = 0; hi_first = 0;
      if (in_seq && gap_len < min_gap) min_gap = gap_len;
    end
    if (spi_cs_n) gap_len++; else gap_len = 0;
    if (!spi_cs_n) begin
      if (spi_sck && !prev_sck) begin obs[63-idx] = spi_mosi; idx++; end
      if (spi_sck) hi_cnt++;
      else if (hi_cnt != 0 && hi_first == 0) hi_first = hi_cnt;
    end
    if (!prev_cs && spi_cs_n) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected frame", 0, obs, 0);
      end else begin
        frame_t e;
        e = exp_q.pop_front();
        chk("R10 frame length", idx == e.n, idx, e.n);
        chk("R3 frame bits", obs == e.bits, obs, e.bits);
        chk("R6 sck high time", hi_first == e.half, hi_first, e.half);
        chk("R8 busy during frame", cycle_busy == 1'b1, cycle_busy, 1);
        if (obs[63:56] == 8'h05 && polls_busy > 0) polls_busy--;
      end
      idx = 0; in_seq = 1; gap_len = 1;
    end
    prev_cs = spi_cs_n; prev_sck = spi_sck;
  end

  function automatic logic [63:0] put(input logic [63:0] acc, input int at, input logic [63:0] val,
                                      input int w);
    for (int b = 0; b < w; b++) acc[63-at-b] = val[w-1-b];
    return acc;
  endfunction

  // Driver: pushes expected frames, pulses go, waits for completion.
  task automatic run_cycle(input int busy_polls, input logic chk_rd, input string tag);
    frame_t f;
    int hf, nb, at;
    logic [31:0] exp_rd, old_rd;
    hf = (cfg_freq == 3'd1 && !cfg_read_cycle) ? H33 : H20;
    nb = cfg_data_en ? cfg_byte_cnt + 1 : 0;
    if (cfg_atomic) begin
      f.bits = put(0, 0, cfg_pfx_sel ? pfx_ops[15:8] : pfx_ops[7:0], 8); f.n = 8; f.half = hf;
      exp_q.push_back(f);
    end
    at = 0; f.bits = 0;
    f.bits = put(f.bits, at, op_menu >> (8*cfg_op_sel), 8); at += 8;
    if (cfg_addr_en) begin f.bits = put(f.bits, at, cfg_addr, 24); at += 24; end
    exp_rd = 0;
    for (int k = 0; k < nb*8; k++) exp_rd = {exp_rd[30:0], slave_pat[63-at-k]};
    if (nb > 0) f.bits = put(f.bits, at, cfg_wdata, nb*8);
    f.n = at + nb*8; f.half = hf;
    exp_q.push_back(f);
    if (cfg_atomic) for (int p = 0; p <= busy_polls; p++) begin
      f.bits = {8'h05, 56'd0}; f.n = 16; f.half = hf; exp_q.push_back(f);
    end
    polls_busy = busy_polls; old_rd = rdata; in_seq = 0; min_gap = 1000;
    go = 1; @(negedge clk); go = 0;
    chk({"R2 busy after go ", tag}, cycle_busy == 1 && cycle_done == 0, {cycle_busy, cycle_done}, 2'b10);
    for (int t = 0; t < 20000 && !cycle_done; t++) @(negedge clk);
    chk({"R8 end flags ", tag}, cycle_done == 1 && cycle_busy == 0, {cycle_busy, cycle_done}, 2'b01);
    chk({"R7 all frames seen ", tag}, exp_q.size() == 0, exp_q.size(), 0);
    if (cfg_atomic) chk({"R10 gap ", tag}, min_gap >= GAPC, min_gap, GAPC);
    if (chk_rd) chk({"R5 rdata ", tag}, rdata == exp_rd, rdata, exp_rd);
    if (!cfg_data_en) chk({"R4 rdata kept ", tag}, rdata == old_rd, rdata, old_rd);
    exp_q.delete();
    repeat (10) @(negedge clk);
    chk({"R8 done held ", tag}, cycle_done == 1, cycle_done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", spi_cs_n == 1, spi_cs_n, 1);
    chk("R1 reset sck/flags", {spi_sck, cycle_busy, cycle_done} == 3'b000,
        {spi_sck, cycle_busy, cycle_done}, 0);
    rst_n = 1; repeat (2) @(negedge clk);
    // R3 R5: one byte, slow rate
    cfg_op_sel = 2; cfg_data_en = 1; cfg_byte_cnt = 0; cfg_wdata = 32'h0000_00A7;
    run_cycle(0, 1, "t1");
    // R5 R6: address plus four bytes, fast rate
    cfg_freq = 1; cfg_addr_en = 1; cfg_addr = 24'h12_34_56; cfg_byte_cnt = 3;
    cfg_wdata = 32'hDEAD_BEEF; cfg_op_sel = 7;
    run_cycle(0, 1, "t2");
    // R4: no data phase, count ignored
    cfg_data_en = 0; cfg_byte_cnt = 3; cfg_op_sel = 4;
    run_cycle(0, 0, "t3");
    // R6: reserved code uses the slow divider
    cfg_freq = 3'd5; cfg_addr_en = 0; cfg_op_sel = 1;
    run_cycle(0, 0, "t4");
    // R6 R5: read cycle forced slow, two bytes
    cfg_freq = 1; cfg_read_cycle = 1; cfg_addr_en = 1; cfg_addr = 24'hABCDEF;
    cfg_data_en = 1; cfg_byte_cnt = 1; cfg_op_sel = 6; cfg_wdata = 32'h0000_1357;
    run_cycle(0, 1, "t5");
    // R7 R8: atomic, prefix 0, busy for two polls
    cfg_read_cycle = 0; cfg_freq = 0; cfg_atomic = 1; cfg_pfx_sel = 0;
    cfg_op_sel = 4; cfg_addr = 24'h00_10_00; cfg_data_en = 0;
    run_cycle(2, 0, "t6");
    // R7: atomic, prefix 1, fast, ready at first poll
    cfg_freq = 1; cfg_pfx_sel = 1; cfg_op_sel = 5; cfg_data_en = 1; cfg_byte_cnt = 2;
    cfg_wdata = 32'h0055_AA11;
    run_cycle(0, 1, "t7");
    // R9: second go mid-sequence is ignored
    cfg_pfx_sel = 0; cfg_op_sel = 3; cfg_data_en = 0;
    fork
      run_cycle(3, 0, "t8");
      begin
        repeat (60) @(negedge clk);
        cfg_op_sel = 0; cfg_atomic = 0; go = 1; @(negedge clk); go = 0;
      end
    join
    repeat (200) @(negedge clk);
    chk("R9 no extra frame", spi_cs_n == 1 && cycle_done == 1, {spi_cs_n, cycle_done}, 2'b11);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule